// File: doc/BRIEF.md
# Shared Address/Data Bus Access Sequencer

This block runs single accesses to an external peripheral whose address and data travel on the same set of wires. When a host request is taken, the block first drives the address onto the shared bus, then drops an active-low address strobe so the peripheral can latch it. After that the same wires carry the data phase. A write drives the data and pulses an active-low write strobe. A read first releases the bus for one turnaround cycle, then pulses an active-low read strobe and samples what the peripheral returns. An active-low chip select stays low from the start of the address phase to the end of recovery.

Every interval is a whole number of clock cycles fixed by parameters. The strobe low times and the recovery times are derived from several component limits, and the block takes the largest of them. A request carries an address, write data, a direction and a size code that picks how many low-order byte lanes are meaningful. The host sees a ready level while the block is idle, a one-cycle done pulse when recovery ends, and the captured read data.

Top module: `muxbus_cycle_gen`

## Requirements
- R1: After reset, csN, adsN, rdN and wrN are high, busOe is 0, rspDone is 0 and reqReady is 1.
- R2: In the cycle after a request is taken, and for ADDR_SU cycles in all, csN is low, adsN is high and busOe is 1, with the address zero-extended to BW bits on busOut.
- R3: For the next ADDR_TH cycles adsN is low and the address is still driven, so the address is held after the strobe falls.
- R4: For a read (reqWrite = 0), exactly one cycle follows the address hold in which busOe is 0, csN is low and the other strobes are high.
- R5: For a write, wrN is low for max(WR_PW, WR_DSU) cycles right after the address hold. During those cycles busOut carries the write data, with the byte lanes at and above 2^reqSize and all bits above DW set to zero.
- R6: After the write strobe, csN stays low and the write data stays driven for a recovery of max(CS_TH, DATA_TH, WR_CYC - WR_PW) cycles, with the other strobes high.
- R7: For a read, rdN is low for max(RD_PW, RD_DOUT) cycles right after the turnaround cycle, with busOe at 0.
- R8: After the read strobe, csN stays low and busOe stays 0 for a recovery of max(CS_TH, DATA_TINV, RD_CYC - RD_PW) cycles.
- R9: rspRdata takes the busIn value from the last cycle in which rdN is low. Byte lanes at and above 2^reqSize are forced to zero (reqSize 0 = 1 byte, 1 = 2 bytes).
- R10: In the cycle after recovery ends, rspDone is 1 for exactly one cycle, csN is high and reqReady is 1.
- R11: From acceptance until rspDone, reqReady is 0. Request inputs that change or stay valid in that time do not alter the ongoing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; a request is taken on this edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Peripheral address |
| reqWdata | input | DW | Write data |
| reqSize | input | SZW | Log2 of the byte count |
| rspRdata | output | DW | Captured read data |
| rspDone | output | 1 | One-cycle pulse when recovery has ended |
| busOut | output | BW | Shared bus value driven by the block |
| busOe | output | 1 | Shared bus output enable |
| busIn | input | BW | Shared bus value from the peripheral |
| adsN | output | 1 | Address strobe, active low |
| csN | output | 1 | Chip select, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
A wrong phase counter or state in this block shows up on the strobe pins within the same access. A phase that runs one cycle long or short moves every later strobe edge and also moves rspDone. The bench therefore compares every pin in every cycle from acceptance to done against a phase schedule it computes itself. A wrong lane mask or capture moment shows only in rspRdata after done, so the peripheral model returns a value that changes every cycle of the read strobe.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ASU,
    S_AHLD,
    S_TURN,
    S_DLOW,
    S_REC
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic selData;
    logic oe;
    logic capture;
  } dpCtl_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int atLeastOne(int a);
    return (a < 1) ? 1 : a;
  endfunction

endpackage

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_SU   = 2,
  parameter int ADDR_TH   = 1,
  parameter int WR_PW     = 3,
  parameter int WR_DSU    = 2,
  parameter int WR_CYC    = 5,
  parameter int RD_PW     = 2,
  parameter int RD_DOUT   = 4,
  parameter int RD_CYC    = 6,
  parameter int CS_TH     = 1,
  parameter int DATA_TH   = 1,
  parameter int DATA_TINV = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output dpCtl_t dpCtl,
  output logic   adsN,
  output logic   csN,
  output logic   rdN,
  output logic   wrN,
  output logic   done
);

  localparam int SuLen   = atLeastOne(ADDR_SU);
  localparam int ThLen   = atLeastOne(ADDR_TH);
  localparam int WrLow   = atLeastOne(maxOf(WR_PW, WR_DSU));
  localparam int WrRec   = atLeastOne(maxOf(maxOf(CS_TH, DATA_TH), WR_CYC - WR_PW));
  localparam int RdLow   = atLeastOne(maxOf(RD_PW, RD_DOUT));
  localparam int RdRec   = atLeastOne(maxOf(maxOf(CS_TH, DATA_TINV), RD_CYC - RD_PW));
  localparam int Longest = maxOf(maxOf(maxOf(SuLen, ThLen), maxOf(WrLow, WrRec)),
                                 maxOf(RdLow, RdRec));
  localparam int CW      = maxOf(1, $clog2(Longest + 1));

  phase_e          state, nState;
  logic [CW-1:0]   cnt, nCnt;
  logic            isWr;
  logic            accept;
  logic            lastTick;

  assign lastTick = (cnt == '0);

  always_comb begin
    nState = state;
    nCnt   = lastTick ? cnt : cnt - CW'(1);
    accept = 1'b0;
    unique case (state)
      S_IDLE: begin
        nCnt = '0;
        if (reqValid) begin
          accept = 1'b1;
          nState = S_ASU;
          nCnt   = CW'(SuLen - 1);
        end
      end
      S_ASU: if (lastTick) begin
        nState = S_AHLD;
        nCnt   = CW'(ThLen - 1);
      end
      S_AHLD: if (lastTick) begin
        if (isWr) begin
          nState = S_DLOW;
          nCnt   = CW'(WrLow - 1);
        end else begin
          nState = S_TURN;
          nCnt   = '0;
        end
      end
      S_TURN: begin
        nState = S_DLOW;
        nCnt   = CW'(RdLow - 1);
      end
      S_DLOW: if (lastTick) begin
        nState = S_REC;
        nCnt   = isWr ? CW'(WrRec - 1) : CW'(RdRec - 1);
      end
      S_REC: if (lastTick) begin
        nState = S_IDLE;
      end
      default: begin
        nState = S_IDLE;
        nCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
      if (accept) isWr <= reqWrite;
      done  <= (state == S_REC) && lastTick;
    end
  end

  assign reqReady = (state == S_IDLE);
  assign csN      = (state == S_IDLE);
  assign adsN     = (state != S_AHLD);
  assign wrN      = !((state == S_DLOW) && isWr);
  assign rdN      = !((state == S_DLOW) && !isWr);

  always_comb begin
    dpCtl.load    = accept;
    dpCtl.selData = (state == S_DLOW) || (state == S_REC);
    dpCtl.oe      = (state == S_ASU) || (state == S_AHLD) ||
                    (isWr && ((state == S_DLOW) || (state == S_REC)));
    dpCtl.capture = (state == S_DLOW) && !isWr && lastTick;
  end

endmodule

// File: rtl/mbc_dpath.sv
module mbc_dpath
  import mbc_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int BW  = 20,
  parameter int SZW = 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtl_t         dpCtl,
  input  logic [AW-1:0]  reqAddr,
  input  logic [DW-1:0]  reqWdata,
  input  logic [SZW-1:0] reqSize,
  input  logic [BW-1:0]  busIn,
  output logic [BW-1:0]  busOut,
  output logic           busOe,
  output logic [DW-1:0]  rdata
);

  localparam int NB = DW / 8;

  logic [AW-1:0]  addrQ;
  logic [DW-1:0]  dataQ;
  logic [SZW-1:0] sizeQ;
  logic [DW-1:0]  rdataQ;

  function automatic logic [DW-1:0] laneMask(input logic [SZW-1:0] sz);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < (1 << int'(sz))) m[i*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      sizeQ  <= '0;
      rdataQ <= '0;
    end else begin
      if (dpCtl.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata & laneMask(reqSize);
        sizeQ <= reqSize;
      end
      if (dpCtl.capture) rdataQ <= busIn[DW-1:0] & laneMask(sizeQ);
    end
  end

  always_comb begin
    busOut = '0;
    if (dpCtl.oe) begin
      if (dpCtl.selData) busOut[DW-1:0] = dataQ;
      else               busOut[AW-1:0] = addrQ;
    end
  end

  assign busOe = dpCtl.oe;
  assign rdata = rdataQ;

endmodule

// File: rtl/muxbus_cycle_gen.sv
module muxbus_cycle_gen
  import mbc_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int ADDR_SU   = 2,
  parameter int ADDR_TH   = 1,
  parameter int WR_PW     = 3,
  parameter int WR_DSU    = 2,
  parameter int WR_CYC    = 5,
  parameter int RD_PW     = 2,
  parameter int RD_DOUT   = 4,
  parameter int RD_CYC    = 6,
  parameter int CS_TH     = 1,
  parameter int DATA_TH   = 1,
  parameter int DATA_TINV = 3,
  localparam int BW       = maxOf(AW, DW),
  localparam int SZW      = (DW / 8 > 1) ? $clog2(DW / 8) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  output logic           reqReady,
  input  logic           reqWrite,
  input  logic [AW-1:0]  reqAddr,
  input  logic [DW-1:0]  reqWdata,
  input  logic [SZW-1:0] reqSize,
  output logic [DW-1:0]  rspRdata,
  output logic           rspDone,
  output logic [BW-1:0]  busOut,
  output logic           busOe,
  input  logic [BW-1:0]  busIn,
  output logic           adsN,
  output logic           csN,
  output logic           rdN,
  output logic           wrN
);

  dpCtl_t dpCtl;

  mbc_ctrl #(
    .ADDR_SU(ADDR_SU), .ADDR_TH(ADDR_TH),
    .WR_PW(WR_PW), .WR_DSU(WR_DSU), .WR_CYC(WR_CYC),
    .RD_PW(RD_PW), .RD_DOUT(RD_DOUT), .RD_CYC(RD_CYC),
    .CS_TH(CS_TH), .DATA_TH(DATA_TH), .DATA_TINV(DATA_TINV)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqReady(reqReady),
    .dpCtl(dpCtl),
    .adsN(adsN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .done(rspDone)
  );

  mbc_dpath #(.AW(AW), .DW(DW), .BW(BW), .SZW(SZW)) i_dpath (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSize(reqSize),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .rdata(rspRdata)
  );

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
  parameter int BW = 20
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqReady,
  input logic          rspDone,
  input logic [BW-1:0] busOut,
  input logic          busOe,
  input logic          adsN,
  input logic          csN,
  input logic          rdN,
  input logic          wrN
);

  // R3: address strobe only inside a selected access
  a_r3_ads_inside_cs: assert property (@(posedge clk) disable iff (!rstN)
    !adsN |-> !csN);

  // R3: bus value unchanged across the strobe's falling edge
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adsN) |-> (busOe && $stable(busOut)));

  // R5: write strobe only with the bus driven
  a_r5_wr_drives: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (busOe && !csN));

  // R7: read strobe only with the bus released
  a_r7_rd_released: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (!busOe && !csN));

  // R8: chip select held past the rising read strobe
  a_r8_cs_after_rd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> !csN);

  // R6: chip select held past the rising write strobe
  a_r6_cs_after_wr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> (!csN && busOe));

  // R10: done lasts one cycle, in idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (reqReady && csN));

  // R11: never ready while selected
  a_r11_busy: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !reqReady);

  // R4: never both strobes
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~rdN, ~wrN, ~adsN}) <= 1);

endmodule

bind muxbus_cycle_gen mbc_checker #(.BW(BW)) i_mbcChecker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspDone(rspDone),
  .busOut(busOut), .busOe(busOe), .adsN(adsN), .csN(csN),
  .rdN(rdN), .wrN(wrN)
);

// File: tb/test_muxbus_cycle_gen.sv
module test_muxbus_cycle_gen;

  localparam int ClkPeriod = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BW = (AW > DW) ? AW : DW;
  localparam int SZW = 1;

  localparam int ADDR_SU = 2, ADDR_TH = 1;
  localparam int WR_PW = 3, WR_DSU = 2, WR_CYC = 5;
  localparam int RD_PW = 2, RD_DOUT = 4, RD_CYC = 6;
  localparam int CS_TH = 1, DATA_TH = 1, DATA_TINV = 3;

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SuN  = mx(1, ADDR_SU);
  localparam int ThN  = mx(1, ADDR_TH);
  localparam int WLow = mx(1, mx(WR_PW, WR_DSU));
  localparam int WRec = mx(1, mx(mx(CS_TH, DATA_TH), WR_CYC - WR_PW));
  localparam int RLow = mx(1, mx(RD_PW, RD_DOUT));
  localparam int RRec = mx(1, mx(mx(CS_TH, DATA_TINV), RD_CYC - RD_PW));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [SZW-1:0] reqSize = '0;
  logic [DW-1:0] rspRdata;
  logic rspDone;
  logic [BW-1:0] busOut;
  logic busOe;
  logic [BW-1:0] busIn;
  logic adsN, csN, rdN, wrN;

  logic [BW-1:0] pBase = '0;
  logic [BW-1:0] rdIdx;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  muxbus_cycle_gen i_muxbus_cycle_gen (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSize(reqSize),
    .rspRdata(rspRdata), .rspDone(rspDone),
    .busOut(busOut), .busOe(busOe), .busIn(busIn),
    .adsN(adsN), .csN(csN), .rdN(rdN), .wrN(wrN)
  );

  // peripheral model: value steps each cycle of the read strobe
  always_ff @(posedge clk) begin
    if (rdN) rdIdx <= '0;
    else     rdIdx <= rdIdx + BW'(1);
  end
  assign busIn = pBase + rdIdx;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] maskFor(input int sz);
    longint bytes = longint'(1) << sz;
    longint m = (longint'(1) << (8 * bytes)) - 1;
    return DW'(m);
  endfunction

  // observed vector: {csN, adsN, rdN, wrN, busOe, reqReady, rspDone, busOut}
  function automatic logic [BW+6:0] obs();
    return {csN, adsN, rdN, wrN, busOe, reqReady, rspDone, busOut};
  endfunction

  task automatic doAccess(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int sz, input logic [BW-1:0] base);
    int total;
    int lowN;
    int recN;
    bit bad[6];
    logic [BW+6:0] firstAct[6];
    logic [BW+6:0] firstExp[6];
    logic [DW-1:0] wExp;
    string names[6];
    names[0] = "R2 address setup";
    names[1] = "R3 address hold";
    names[2] = "R4 turnaround";
    names[3] = wr ? "R5 write strobe" : "R7 read strobe";
    names[4] = wr ? "R6 write recovery" : "R8 read recovery";
    names[5] = "R11 busy";
    for (int p = 0; p < 6; p++) begin
      bad[p] = 0; firstAct[p] = '0; firstExp[p] = '0;
    end
    lowN = wr ? WLow : RLow;
    recN = wr ? WRec : RRec;
    total = SuN + ThN + (wr ? 0 : 1) + lowN + recN;
    wExp = d & maskFor(sz);
    pBase = base;

    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqSize = SZW'(sz);
    @(posedge clk);
    #1;
    // R11: keep a valid, different request present while busy
    reqWrite = !wr; reqAddr = ~a; reqWdata = ~d; reqSize = SZW'(1 - sz);
    for (int k = 0; k < total; k++) begin
      int ph;
      int t;
      logic [BW+6:0] e;
      logic [BW-1:0] bv;
      bit cs, ad, rd, wn, oe;
      @(negedge clk);
      t = k - SuN - ThN;
      if (k < SuN) ph = 0;
      else if (k < SuN + ThN) ph = 1;
      else if (!wr && t == 0) ph = 2;
      else if ((wr ? t : t - 1) < lowN) ph = 3;
      else ph = 4;
      cs = 0; ad = (ph != 1); rd = 1; wn = 1; oe = 0; bv = '0;
      if (ph <= 1) begin oe = 1; bv = BW'(a); end
      if (ph == 3) begin if (wr) wn = 0; else rd = 0; end
      if (wr && ph >= 3) begin oe = 1; bv = BW'(wExp); end
      e = {cs, ad, rd, wn, oe, 1'b0, 1'b0, bv};
      if (obs() !== e) begin
        if (!bad[ph]) begin firstAct[ph] = obs(); firstExp[ph] = e; end
        bad[ph] = 1;
      end
      if (reqReady !== 1'b0) bad[5] = 1;
    end
    for (int p = 0; p < 5; p++) begin
      if (p != 2 || !wr) check(!bad[p], names[p], 64'(firstAct[p]), 64'(firstExp[p]));
    end
    check(!bad[5], names[5], 64'(bad[5]), 64'd0);
    @(negedge clk);
    // R10: done pulse in the idle cycle after recovery
    check(rspDone === 1'b1 && reqReady === 1'b1 && csN === 1'b1, "R10 done",
          64'({rspDone, reqReady, csN}), 64'h7);
    reqValid = 1'b0;
    @(negedge clk);
    check(rspDone === 1'b0 && csN === 1'b1, "R10 done one cycle",
          64'({rspDone, csN}), 64'h1);
    if (!wr) begin
      logic [DW-1:0] rExp;
      logic [BW-1:0] last;
      last = base + BW'(RLow - 1);
      rExp = last[DW-1:0] & maskFor(sz);
      check(rspRdata === rExp, "R9 read capture", 64'(rspRdata), 64'(rExp));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] addrs[3];
    logic [DW-1:0] datas[3];
    logic [BW-1:0] bases[3];
    addrs[0] = '0;            datas[0] = 16'hFFFF; bases[0] = 20'h0A5F0;
    addrs[1] = '1;            datas[1] = 16'h0000; bases[1] = 20'hFFFFE;
    addrs[2] = 20'h5A3C1;     datas[2] = 16'hB7C4; bases[2] = 20'h1234C;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle state during reset
    check({csN, adsN, rdN, wrN, busOe, rspDone, reqReady} === 7'b1111001, "R1 reset",
          64'({csN, adsN, rdN, wrN, busOe, rspDone, reqReady}), 64'b1111001);
    rstN = 1'b1;
    @(negedge clk);
    check({csN, adsN, rdN, wrN, busOe, rspDone, reqReady} === 7'b1111001, "R1 after reset",
          64'({csN, adsN, rdN, wrN, busOe, rspDone, reqReady}), 64'b1111001);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 3; p++)
          doAccess(w[0], addrs[p], datas[p], s, bases[p]);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule